// File: doc/BRIEF.md
# Burst Word Address Order Generator

This block produces the word address for every data phase of a memory burst. A start command carries a starting word address, a 2-bit ordering mode and a programmable cache line size in words. The block then presents the first word address and moves to the next one each time a data-phase-complete strobe arrives. Between strobes the address does not change. Three orderings are supported. Linear counts straight up. Toggle and wrap are critical-word-first orderings that stay inside the current cache line and then continue in the next line at the same starting offset.

When the requested ordering cannot be honoured, the block raises a terminate request together with the first word. This covers the reserved mode code, and it covers a line-ordered mode whose line size is not 4, 8 or 16 words. The burst then ends after that single word. The bus handshake and the data path belong to the surrounding logic.

The block is a four-state machine:
- IDLE: no burst is in progress.
- LINEAR: an incrementing burst is in progress.
- CRIT: a toggle or wrap burst is in progress.
- LAST: a single-word burst with the terminate request raised.

The transitions are as follows:
- Any state goes to LINEAR, CRIT or LAST on a start command, chosen from the mode and the line size.
- LAST goes to IDLE on a strobe.
- LINEAR and CRIT stay where they are on each strobe until the next start.
- IDLE ignores strobes.

Top module: `burst_seq_gen`

## Requirements
- R1: After reset, `active` is 0, `term_req` is 0 and `cur_addr` is 0.
- R2: A start command sampled at a clock edge makes `cur_addr` equal `start_addr` and `active` equal 1 after that edge. A start takes priority over a strobe in the same cycle and restarts any burst in progress.
- R3: While a burst is active and neither start nor strobe is asserted, `cur_addr` and `term_req` hold their values.
- R4: The linear mode (`order_mode` = 2'b00) adds one to `cur_addr` on each strobe, modulo 2^ADDR_W. It never raises `term_req`, and `line_words` has no effect on it.
- R5: Toggle mode (`order_mode` = 2'b10) is defined in terms of the line size L, the starting offset s = start mod L, and the beat number j within the line. Beat j of a line is at line base + (s XOR j). After L beats, the burst moves to the next line base (+L) at offset s.
- R6: Wrap mode (`order_mode` = 2'b11) puts beat j of a line at line base + ((s + j) mod L). After L beats, it moves to the next line base at offset s.
- R7: With a supported line size and a starting offset of zero, the linear, toggle and wrap modes give the same address sequence.
- R8: The reserved mode (`order_mode` = 2'b01) presents the start address with `term_req` = 1. After one strobe, `active` and `term_req` return to 0.
- R9: In toggle or wrap mode, a `line_words` value other than 4, 8 or 16 (zero included) gives the same single-word behaviour as R8.
- R10: With no burst active, a strobe is ignored: `cur_addr` keeps its last value and `active` and `term_req` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start a new burst (one-cycle pulse) |
| start_addr | input | ADDR_W | Word address of the first data phase |
| order_mode | input | 2 | 00 linear, 01 reserved, 10 toggle, 11 wrap |
| line_words | input | LSZ_W | Cache line size in words, sampled at start |
| beat_done | input | 1 | Data-phase-complete strobe |
| cur_addr | output | ADDR_W | Word address of the current data phase |
| active | output | 1 | A burst is in progress |
| term_req | output | 1 | Request to end the burst after the current word |

## Verification
The bench builds the block with ADDR_W = 10, keeping the other defaults. A narrow address space lets random start addresses sit near the top of the range. Linear and line-ordered bursts then roll over from the highest address to zero, and that rollover is checked against the model. Keeping LSZ_W at 8 lets the bench drive unsupported line sizes such as 0, 12 and 32. These sit next to the supported powers of two, so the fallback to single-word transfers is tested right at its edges.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        ORD_LINEAR = 2'b00,
        ORD_RSVD   = 2'b01,
        ORD_TOGGLE = 2'b10,
        ORD_WRAP   = 2'b11
    } order_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LINEAR,
        ST_CRIT,
        ST_LAST
    } seq_state_e;

endpackage

// File: rtl/bsg_line_decode.sv
// Maps a programmed line size in words onto a supported flag and an offset mask.
module bsg_line_decode #(
    parameter int LSZ_W   = 8,
    parameter int MIN_LOG = 2,
    parameter int MAX_LOG = 4
) (
    input  logic [LSZ_W-1:0]   line_words,
    output logic               supported,
    output logic [MAX_LOG-1:0] off_mask
);
    logic [MAX_LOG:MIN_LOG] hit;

    for (genvar g = MIN_LOG; g <= MAX_LOG; g++) begin : g_size
        assign hit[g] = (line_words == LSZ_W'(1 << g));
    end

    always_comb begin
        off_mask = '0;
        for (int g = MIN_LOG; g <= MAX_LOG; g++) begin
            if (hit[g]) off_mask = MAX_LOG'((1 << g) - 1);
        end
    end

    assign supported = |hit;

endmodule

// File: rtl/bsg_beat_offset.sv
// Word offset within the line for a given beat: XOR for toggle, modular add for wrap.
module bsg_beat_offset #(
    parameter int OFF_W = 4
) (
    input  logic [OFF_W-1:0] first_off,
    input  logic [OFF_W-1:0] beat_idx,
    input  logic [OFF_W-1:0] off_mask,
    input  logic             wrap_mode,
    output logic [OFF_W-1:0] word_off
);
    logic [OFF_W-1:0] sum_off;
    logic [OFF_W-1:0] xor_off;

    assign sum_off  = first_off + beat_idx;
    assign xor_off  = first_off ^ beat_idx;
    assign word_off = (wrap_mode ? sum_off : xor_off) & off_mask;

endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int LSZ_W   = 8,
    parameter int MAX_LOG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [1:0]        order_mode,
    input  logic [LSZ_W-1:0]  line_words,
    input  logic              beat_done,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              active,
    output logic              term_req
);
    localparam int OFF_W = MAX_LOG;

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [OFF_W-1:0]  soff_q, soff_d;
    logic [OFF_W-1:0]  beat_q, beat_d;
    logic [OFF_W-1:0]  mask_q, mask_d;
    logic              wrap_q, wrap_d;

    logic              dec_ok;
    logic [OFF_W-1:0]  dec_mask;
    logic [OFF_W-1:0]  beat_nxt;
    logic [OFF_W-1:0]  word_off;
    logic              line_end;
    logic [ADDR_W-1:0] line_step;
    order_e            req_order;

    bsg_line_decode #(
        .LSZ_W  (LSZ_W),
        .MIN_LOG(2),
        .MAX_LOG(MAX_LOG)
    ) u_dec (
        .line_words(line_words),
        .supported (dec_ok),
        .off_mask  (dec_mask)
    );

    assign beat_nxt  = (beat_q + 1'b1) & mask_q;
    assign line_end  = (beat_q == mask_q);
    assign line_step = ADDR_W'(mask_q) + ADDR_W'(1);
    assign req_order = order_e'(order_mode);

    bsg_beat_offset #(
        .OFF_W(OFF_W)
    ) u_off (
        .first_off(soff_q),
        .beat_idx (beat_nxt),
        .off_mask (mask_q),
        .wrap_mode(wrap_q),
        .word_off (word_off)
    );

    // Next-state and next-address logic
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        base_d  = base_q;
        soff_d  = soff_q;
        beat_d  = beat_q;
        mask_d  = mask_q;
        wrap_d  = wrap_q;
        if (start) begin
            addr_d = start_addr;
            mask_d = dec_mask;
            soff_d = start_addr[OFF_W-1:0] & dec_mask;
            base_d = start_addr & ~ADDR_W'(dec_mask);
            beat_d = '0;
            wrap_d = (req_order == ORD_WRAP);
            unique case (req_order)
                ORD_LINEAR: state_d = ST_LINEAR;
                ORD_RSVD:   state_d = ST_LAST;
                ORD_TOGGLE,
                ORD_WRAP:   state_d = dec_ok ? ST_CRIT : ST_LAST;
            endcase
        end else if (beat_done) begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_LINEAR: addr_d  = addr_q + ADDR_W'(1);
                ST_CRIT: begin
                    base_d = line_end ? (base_q + line_step) : base_q;
                    addr_d = base_d | ADDR_W'(word_off);
                    beat_d = beat_nxt;
                end
                ST_LAST:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            base_q  <= '0;
            soff_q  <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            wrap_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            base_q  <= base_d;
            soff_q  <= soff_d;
            beat_q  <= beat_d;
            mask_q  <= mask_d;
            wrap_q  <= wrap_d;
        end
    end

    // Outputs
    always_comb begin
        cur_addr = addr_q;
        active   = (state_q != ST_IDLE);
        term_req = (state_q == ST_LAST);
    end

    // Assertions
    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cur_addr == $past(start_addr)) && active);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active && !start && !beat_done |=> $stable(cur_addr) && $stable(term_req));

    assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LINEAR) && beat_done && !start
        |=> (cur_addr == $past(cur_addr) + ADDR_W'(1)) && !term_req);

    assert_rsvd_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start && (order_mode == 2'b01) |=> term_req);

    assert_unsup_term_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start && order_mode[1] &&
        !(line_words == LSZ_W'(4) || line_words == LSZ_W'(8) || line_words == LSZ_W'(16))
        |=> term_req);

    assert_single_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        term_req && beat_done && !start |=> !active && !term_req);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active && !start |=> !active && !term_req && $stable(cur_addr));

endmodule

// File: tb/burst_seq_gen_tb_top.sv
module burst_seq_gen_tb_top;
    localparam int AW = 10;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [1:0]    order_mode = 2'b00;
    logic [LW-1:0] line_words = '0;
    logic          beat_done = 1'b0;
    logic [AW-1:0] cur_addr;
    logic          active;
    logic          term_req;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    burst_seq_gen #(.ADDR_W(AW), .LSZ_W(LW), .MAX_LOG(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .order_mode(order_mode), .line_words(line_words), .beat_done(beat_done),
        .cur_addr(cur_addr), .active(active), .term_req(term_req)
    );

    function automatic bit exp_term(logic [1:0] m, int l);
        return (m == 2'b01) || (m[1] && !(l == 4 || l == 8 || l == 16));
    endfunction

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] a, logic [1:0] m, int l, int k);
        int s0, j, ln, off;
        logic [AW-1:0] base;
        if (m == 2'b00) return a + AW'(k);
        s0 = int'(a) % l;
        base = a - AW'(s0);
        ln = k / l;
        j = k % l;
        off = (m == 2'b10) ? (s0 ^ j) : ((s0 + j) % l);
        return base + AW'(ln * l + off);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic start_cmd(logic [AW-1:0] a, logic [1:0] m, int l, bit with_strobe);
        start = 1'b1; start_addr = a; order_mode = m; line_words = LW'(l);
        beat_done = with_strobe;
        @(negedge clk);
        start = 1'b0; beat_done = 1'b0;
    endtask

    task automatic strobe();
        beat_done = 1'b1;
        @(negedge clk);
        beat_done = 1'b0;
    endtask

    task automatic run_burst(string tag, logic [AW-1:0] a, logic [1:0] m, int l, int n, bit gaps);
        start_cmd(a, m, l, 1'b0);
        chk({tag, "/R2 first addr"}, 32'(cur_addr), 32'(a));
        chk({tag, "/R2 active"}, 32'(active), 32'd1);
        if (exp_term(m, l)) begin
            chk({tag, " term_req"}, 32'(term_req), 32'd1);
            strobe();
            chk({tag, " ends after one word"}, 32'(active), 32'd0);
            chk({tag, " term_req drops"}, 32'(term_req), 32'd0);
        end else begin
            for (int k = 1; k < n; k++) begin
                if (gaps && ($urandom % 4 == 0)) begin
                    @(negedge clk);
                    chk("R3 hold", 32'(cur_addr), 32'(exp_addr(a, m, l, k - 1)));
                end
                strobe();
                chk({tag, " addr"}, 32'(cur_addr), 32'(exp_addr(a, m, l, k)));
                chk({tag, " no term"}, 32'(term_req), 32'd0);
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 active", 32'(active), 32'd0);
        chk("R1 term_req", 32'(term_req), 32'd0);
        chk("R1 addr", 32'(cur_addr), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 strobe while idle
        strobe();
        chk("R10 idle addr", 32'(cur_addr), 32'd0);
        chk("R10 idle active", 32'(active), 32'd0);
        // R4 linear with rollover, line size ignored
        run_burst("R4", 10'h3FC, 2'b00, 0, 7, 1'b0);
        run_burst("R4", 10'h011, 2'b00, 12, 5, 1'b0);
        // R5 toggle
        run_burst("R5", 10'h105, 2'b10, 8, 12, 1'b0);
        run_burst("R5", 10'h3F2, 2'b10, 4, 10, 1'b0);
        // R6 wrap
        run_burst("R6", 10'h10E, 2'b11, 16, 20, 1'b0);
        run_burst("R6", 10'h3FD, 2'b11, 4, 9, 1'b0);
        // R7 offset zero: all modes match linear
        for (int mi = 0; mi < 4; mi++) begin
            if (mi == 1) continue;
            start_cmd(10'h080, 2'(mi), 4, 1'b0);
            for (int k = 0; k < 4; k++) begin
                if (k > 0) strobe();
                chk("R7 same order", 32'(cur_addr), 32'(10'h080 + k));
            end
        end
        // R8 reserved mode
        run_burst("R8", 10'h123, 2'b01, 8, 1, 1'b0);
        // R10 after terminated burst: strobe ignored, address kept
        strobe();
        chk("R10 addr kept", 32'(cur_addr), 32'h123);
        chk("R10 stays idle", 32'(active), 32'd0);
        // R9 unsupported line sizes
        run_burst("R9", 10'h045, 2'b10, 12, 1, 1'b0);
        run_burst("R9", 10'h046, 2'b11, 0, 1, 1'b0);
        run_burst("R9", 10'h047, 2'b11, 32, 1, 1'b0);
        // R2 restart mid-burst, start beats a simultaneous strobe
        start_cmd(10'h200, 2'b11, 8, 1'b0);
        strobe();
        strobe();
        start_cmd(10'h055, 2'b10, 4, 1'b1);
        chk("R2 restart addr", 32'(cur_addr), 32'h055);
        strobe();
        chk("R2 restart order", 32'(cur_addr), 32'h054);
        // Random bursts
        for (int i = 0; i < 150; i++) begin
            logic [1:0] m;
            int l, pick, n;
            m = 2'($urandom % 4);
            pick = $urandom % 6;
            l = (pick < 3) ? (4 << pick) : int'($urandom % 40);
            n = 1 + int'($urandom % 40);
            case (m)
                2'b00:   run_burst("R4 rnd", AW'($urandom), m, l, n, 1'b1);
                2'b01:   run_burst("R8 rnd", AW'($urandom), m, l, n, 1'b1);
                2'b10:   run_burst(exp_term(m, l) ? "R9 rnd" : "R5 rnd", AW'($urandom), m, l, n, 1'b1);
                default: run_burst(exp_term(m, l) ? "R9 rnd" : "R6 rnd", AW'($urandom), m, l, n, 1'b1);
            endcase
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule